// File: doc/BRIEF.md
# Quasi-Bidirectional Port Pin Driver

This block drives a small group of port pins the way a legacy keyboard-controller port does. Each pin has a data bit from the controller core. A global controller-mode input picks how the pins are driven. With controller mode on, a 0 pulls the pin low. A fresh rise to 1 gives a short strong high pulse, after which the pin is left to a pull-up. A global open-drain input replaces the strong pulse with a plain release, so a pin can share a wire with another open-drain source.

With controller mode off, each pin obeys its general-purpose direction and inversion bits. With controller mode on, those bits are ignored. The block registers every pin output, so all outputs change on the clock edge that follows their inputs. The pad level is sampled back so the core can read pins that sit high only through a pull-up. One or more pins can be marked as relying on a pull-up outside the chip. Their internal weak pull-up enable then stays off.

Top module: `qbd_port_drv`

## Requirements
- R1: In controller mode, a pin whose data bit is 0 at a clock edge shows pin_oe=1 and pin_out=0 after that edge.
- R2: In controller mode with open-drain off, a 0-to-1 change of a data bit drives that pin with pin_oe=1 and pin_out=1 for exactly PULSE_CLKS clock cycles, and then pin_oe returns to 0.
- R3: While a pin is not driven (pin_oe=0), pin_wpu is 1 for pins whose EXT_PU_MASK bit is 0. For pins whose EXT_PU_MASK bit is 1, pin_wpu is always 0.
- R4: A data bit that stays at 1 never starts another strong-high pulse. After the pulse ends, the pin stays released for as long as the bit holds 1.
- R5: A data bit that returns to 0 during a pulse ends the pulse at once, and the pin is driven low after the next edge. A later 0-to-1 change gives a full PULSE_CLKS pulse again.
- R6: In controller mode with open-drain on, a data bit of 1 gives pin_oe=0 and pin_out=0 after the next edge, with no strong-high cycle.
- R7: In controller mode, cfg_dir and cfg_inv have no effect on pin_out, pin_oe or pin_wpu.
- R8: With controller mode off, each pin shows pin_oe=cfg_dir and pin_out=port_data XOR cfg_inv after the next edge. cfg_dir=1 means driven.
- R9: During synchronous reset (rst_n=0), all pins show pin_oe=0 and pin_out=0, and pin_wpu shows the internal pull-up pins. Reset treats every data bit's previous value as 1, so a data bit already at 1 when reset ends gives no pulse.
- R10: pin_rd shows the pad_in value sampled at the previous clock edge. It is cleared to 0 by reset.
- R11: pin_wpu and pin_oe are never both 1 on the same pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_mode | input | 1 | 1 = controller mode, 0 = general-purpose configuration |
| od_mode | input | 1 | 1 = open-drain drive in controller mode |
| port_data | input | NUM_PINS | Port data bits from the controller core |
| cfg_dir | input | NUM_PINS | General-purpose direction, 1 = driven |
| cfg_inv | input | NUM_PINS | General-purpose inversion, 1 = inverted |
| pad_in | input | NUM_PINS | Level seen on each pad |
| pin_out | output | NUM_PINS | Output value per pin |
| pin_oe | output | NUM_PINS | Output enable per pin |
| pin_wpu | output | NUM_PINS | Internal weak pull-up enable per pin |
| pin_rd | output | NUM_PINS | Sampled pad level per pin |

## Verification
The bench builds the block with four pins, a six-cycle pulse, and the top pin marked as relying on an external pull-up. Both pull-up variants are therefore present. With four pins, the general-purpose path can be swept exhaustively over every data, direction and inversion pattern. The controller mode can be swept over every data pattern against every direction and inversion pattern, in both drive styles. The pulse length, its cancellation and the absence of retrigger are measured cycle by cycle on each pin.

// File: rtl/qbd_pkg.sv
// Package: types shared by the port pin driver.
// Assumes: nothing beyond IEEE 1800-2017.
package qbd_pkg;
    // How a pin is driven while controller mode is active.
    typedef enum logic [1:0] {
        DRV_LOW  = 2'd0,
        DRV_HIGH = 2'd1,
        DRV_OFF  = 2'd2
    } drive_e;
endpackage

// File: rtl/qbd_pulse_timer.sv
// Module: per-pin strong-high pulse timer.
// Detects a 0-to-1 change of the data bit and counts the strong-drive window.
// The counter only runs while arm_en (controller mode, not open-drain) is high.
// Assumes: PULSE_CLKS >= 1; synchronous active-low reset.
module qbd_pulse_timer #(
    parameter int PULSE_CLKS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_en,
    input  logic data,
    output logic rise,
    output logic pulse_on
);
    localparam int CNT_W = (PULSE_CLKS < 2) ? 1 : $clog2(PULSE_CLKS);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CLKS - 1);

    logic             prev_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_n;

    assign rise     = data & ~prev_q;
    assign pulse_on = (cnt_q != '0);

    // Next count: load on a rise, count down while data holds 1, clear otherwise.
    always_comb begin
        if (!arm_en || !data) begin
            cnt_n = '0;
        end else if (rise) begin
            cnt_n = LOAD;
        end else if (cnt_q != '0) begin
            cnt_n = cnt_q - 1'b1;
        end else begin
            cnt_n = '0;
        end
    end

    // Hold the previous data bit and the remaining pulse count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            cnt_q  <= '0;
        end else begin
            prev_q <= data;
            cnt_q  <= cnt_n;
        end
    end

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD);

    p_no_retrigger_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (data && !rise && !pulse_on) |=> !pulse_on);

    p_cancel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!data) |=> !pulse_on);
endmodule

// File: rtl/qbd_pin_ctrl.sv
// Module: per-pin output stage.
// Picks the output value, output enable and weak pull-up enable, all registered.
// Assumes: rise and pulse_on come from the pin's qbd_pulse_timer in the same cycle.
module qbd_pin_ctrl
    import qbd_pkg::*;
#(
    parameter bit HAS_INT_PU = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl,
    input  logic od,
    input  logic data,
    input  logic dir,
    input  logic inv,
    input  logic rise,
    input  logic pulse_on,
    output logic out_q,
    output logic oe_q,
    output logic pu_q
);
    drive_e drv;
    logic   out_n;
    logic   oe_n;
    logic   pu_n;

    // Controller-mode drive choice: low, strong high pulse, or released.
    always_comb begin
        if (!data) begin
            drv = DRV_LOW;
        end else if (!od && (rise || pulse_on)) begin
            drv = DRV_HIGH;
        end else begin
            drv = DRV_OFF;
        end
    end

    // Next pin state: controller mode overrides the general-purpose bits.
    always_comb begin
        if (!ctl) begin
            oe_n  = dir;
            out_n = data ^ inv;
        end else begin
            case (drv)
                DRV_LOW:  begin oe_n = 1'b1; out_n = 1'b0; end
                DRV_HIGH: begin oe_n = 1'b1; out_n = 1'b1; end
                default:  begin oe_n = 1'b0; out_n = 1'b0; end
            endcase
        end
        pu_n = HAS_INT_PU ? ~oe_n : 1'b0;
    end

    // Register the pin outputs; reset releases the pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
            oe_q  <= 1'b0;
            pu_q  <= HAS_INT_PU;
        end else begin
            out_q <= out_n;
            oe_q  <= oe_n;
            pu_q  <= pu_n;
        end
    end

    p_low_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl && !data) |=> (oe_q && !out_q));

    p_pulse_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl && !od && rise) |=> (oe_q && out_q));

    p_ext_pu_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        HAS_INT_PU || !pu_q);

    p_od_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl && od && data) |=> (!oe_q && !out_q));

    p_gp_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl) |=> (oe_q == $past(dir) && out_q == $past(data ^ inv)));

    p_pu_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(pu_q && oe_q));
endmodule

// File: rtl/qbd_pad_sampler.sv
// Module: registers the pad levels for readback by the core.
// Assumes: pad_in is already synchronous to clk.
module qbd_pad_sampler #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] rd_q
);
    // Capture the pad levels every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= pad_in;
        end
    end

    p_sample_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rd_q == $past(pad_in)));
endmodule

// File: rtl/qbd_port_drv.sv
// Module: top of the quasi-bidirectional port pin driver.
// Builds one timer and one output stage per pin, plus the pad readback.
// Assumes: EXT_PU_MASK bit set = that pin relies on a pull-up outside the chip.
module qbd_port_drv #(
    parameter int                  NUM_PINS    = 4,
    parameter int                  PULSE_CLKS  = 6,
    parameter logic [NUM_PINS-1:0] EXT_PU_MASK = {1'b1, {(NUM_PINS-1){1'b0}}}
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_mode,
    input  logic                od_mode,
    input  logic [NUM_PINS-1:0] port_data,
    input  logic [NUM_PINS-1:0] cfg_dir,
    input  logic [NUM_PINS-1:0] cfg_inv,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_wpu,
    output logic [NUM_PINS-1:0] pin_rd
);
    localparam logic [NUM_PINS-1:0] INT_PU_MASK = ~EXT_PU_MASK;

    logic arm_en;
    logic [NUM_PINS-1:0] rise;
    logic [NUM_PINS-1:0] pulse_on;

    assign arm_en = ctl_mode & ~od_mode;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        qbd_pulse_timer #(
            .PULSE_CLKS (PULSE_CLKS)
        ) u_timer (
            .clk      (clk),
            .rst_n    (rst_n),
            .arm_en   (arm_en),
            .data     (port_data[i]),
            .rise     (rise[i]),
            .pulse_on (pulse_on[i])
        );

        qbd_pin_ctrl #(
            .HAS_INT_PU (INT_PU_MASK[i])
        ) u_ctrl (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctl      (ctl_mode),
            .od       (od_mode),
            .data     (port_data[i]),
            .dir      (cfg_dir[i]),
            .inv      (cfg_inv[i]),
            .rise     (rise[i]),
            .pulse_on (pulse_on[i]),
            .out_q    (pin_out[i]),
            .oe_q     (pin_oe[i]),
            .pu_q     (pin_wpu[i])
        );
    end

    qbd_pad_sampler #(
        .WIDTH (NUM_PINS)
    ) u_sampler (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .rd_q   (pin_rd)
    );

    p_reset_rel_r9: assert property (@(posedge clk)
        !rst_n |=> ($past(rst_n) || (pin_oe == '0 && pin_wpu == INT_PU_MASK)));
endmodule

// File: tb/tb_qbd_port_drv.sv
// Bench for qbd_port_drv: exhaustive sweeps on four pins with a six-cycle pulse.
module tb_qbd_port_drv;
    localparam int N = 4;
    localparam int PW = 6;
    localparam logic [N-1:0] EXT = 4'b1000;
    localparam logic [N-1:0] INTP = ~EXT;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_mode = 1'b0, od_mode = 1'b0;
    logic [N-1:0] port_data = '0, cfg_dir = '0, cfg_inv = '0, pad_in = '0;
    logic [N-1:0] pin_out, pin_oe, pin_wpu, pin_rd;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    qbd_port_drv #(.NUM_PINS(N), .PULSE_CLKS(PW), .EXT_PU_MASK(EXT)) dut (
        .clk(clk), .rst_n(rst_n), .ctl_mode(ctl_mode), .od_mode(od_mode),
        .port_data(port_data), .cfg_dir(cfg_dir), .cfg_inv(cfg_inv),
        .pad_in(pad_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_wpu(pin_wpu), .pin_rd(pin_rd));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    // Measure a strong-high pulse on pin p after a rise driven at this negedge.
    task automatic measure(input int p, output int len);
        len = 0;
        for (int k = 0; k < PW + 4; k++) begin
            cyc();
            if (pin_oe[p] && pin_out[p]) len++;
            else break;
        end
    endtask

    initial begin
        int len;
        // R9: reset state with data already at 1
        ctl_mode = 1'b1; od_mode = 1'b0; port_data = 4'hF;
        cyc(); cyc();
        chk(pin_oe == 0 && pin_out == 0, "R9 reset drive", {pin_oe, pin_out}, 0);
        chk(pin_wpu == INTP, "R9 reset pull-up", pin_wpu, INTP);
        chk(pin_rd == 0, "R10 reset readback", pin_rd, 0);
        rst_n = 1'b1;
        cyc();
        chk(pin_oe == 0, "R9 no pulse after reset", pin_oe, 0);
        chk(pin_wpu == INTP, "R3 pull-up after reset", pin_wpu, INTP);

        // R2 R3 R4 R5: pulse timing per pin
        for (int p = 0; p < N; p++) begin
            port_data = '0;
            cyc();
            chk(pin_oe == 4'hF && pin_out == 0, "R1 all low", pin_oe, 4'hF);
            port_data[p] = 1'b1;
            measure(p, len);
            chk(len == PW, "R2 pulse length", len, PW);
            chk(!pin_oe[p] && pin_wpu[p] == INTP[p], "R3 release", {pin_oe[p], pin_wpu[p]}, {1'b0, INTP[p]});
            for (int k = 0; k < 10; k++) cyc();
            chk(!pin_oe[p], "R4 held high no retrigger", pin_oe[p], 0);
            port_data[p] = 1'b0;
            cyc();
            port_data[p] = 1'b1;
            cyc(); cyc();
            port_data[p] = 1'b0;
            cyc();
            chk(pin_oe[p] && !pin_out[p], "R5 cancel drives low", {pin_oe[p], pin_out[p]}, 2'b10);
            port_data[p] = 1'b1;
            measure(p, len);
            chk(len == PW, "R5 full pulse after cancel", len, PW);
        end

        // R6 R7 R1: open-drain, every data pattern against every cfg pattern
        od_mode = 1'b1;
        for (int d = 0; d < 16; d++) begin
            for (int c = 0; c < 256; c++) begin
                port_data = d[3:0]; cfg_dir = c[3:0]; cfg_inv = c[7:4];
                cyc();
                chk(pin_oe == ~d[3:0] && pin_out == 0 && pin_wpu == (INTP & d[3:0]),
                    "R6 R7 open-drain", {pin_oe, pin_out, pin_wpu},
                    {~d[3:0], 4'h0, INTP & d[3:0]});
            end
        end

        // R7 R1 R4: quasi mode, settle each pattern then sweep cfg
        od_mode = 1'b0;
        for (int d = 0; d < 16; d++) begin
            port_data = d[3:0];
            for (int k = 0; k < PW + 2; k++) cyc();
            for (int c = 0; c < 256; c++) begin
                cfg_dir = c[3:0]; cfg_inv = c[7:4];
                cyc();
                chk(pin_oe == ~d[3:0] && pin_out == 0 && pin_wpu == (INTP & d[3:0]),
                    "R7 R1 quasi cfg ignored", {pin_oe, pin_out, pin_wpu},
                    {~d[3:0], 4'h0, INTP & d[3:0]});
            end
        end

        // R8 R3 R11: general-purpose mode, exhaustive
        ctl_mode = 1'b0;
        for (int d = 0; d < 16; d++) begin
            for (int c = 0; c < 256; c++) begin
                port_data = d[3:0]; cfg_dir = c[3:0]; cfg_inv = c[7:4];
                od_mode = d[0] ^ c[0];
                cyc();
                chk(pin_oe == c[3:0] && pin_out == (d[3:0] ^ c[7:4]) &&
                    pin_wpu == (INTP & ~c[3:0]) && (pin_wpu & pin_oe) == 0,
                    "R8 R11 general-purpose", {pin_oe, pin_out, pin_wpu},
                    {c[3:0], d[3:0] ^ c[7:4], INTP & ~c[3:0]});
            end
        end

        // R10: readback of every pad pattern
        for (int v = 0; v < 16; v++) begin
            pad_in = v[3:0];
            cyc();
            chk(pin_rd == v[3:0], "R10 readback", pin_rd, v);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule